// File: doc/BRIEF.md
# I2C Slave Controller with Status-Code Reporting

This block is the target side of an I2C bus. It watches the open-drain clock and data lines, recognises START, repeated START and STOP, and compares the first byte of each transfer with a programmable 7-bit own address. It can also answer the all-zero general-call address. Once addressed, it works as a slave receiver (write transfers) or as a slave transmitter (read transfers). It can pull either line low through its two drive outputs.

Each bus event is reported as an 8-bit status code, and an interrupt flag is raised with it. After an addressing or data event, the block holds SCL low until the host clears the flag with a one-cycle `flag_clear` pulse. That pulse is also where the host hands over the next transmit byte. The level of `ack_enable` decides whether the block acknowledges an address or a received byte. When it is low while a transmit byte is loaded, that byte is marked as the last one.

Both lines pass through a synchroniser and a stability filter before any edge is detected. A pulse shorter than the filter length is therefore never seen.

Top module: `i2c_status_slave`

## Requirements
- R1: After reset, `status` reads 0xF8 (the no-event code), `irq_flag` is 0, and both drive outputs are 0. Afterwards, `irq_flag` is 1 exactly when `status` differs from 0xF8.
- R2: A START followed by the own address and a write bit (0) is acknowledged by pulling SDA low in the ninth clock when `ack_enable` is 1. When that acknowledge clock falls, `status` becomes 0x60, `irq_flag` is set and SCL is held low.
- R3: While SCL is being held, the hold stays until `flag_clear` is pulsed. The pulse drops `irq_flag`, returns `status` to 0xF8 and releases SCL.
- R4: An address that differs from `own_addr`, or any address while `ack_enable` is 0, is not acknowledged (SDA stays high in the ninth clock) and raises no flag.
- R5: The address 0 with a write bit is acknowledged with status 0x70 only when `gc_enable` is 1. Otherwise it is ignored like a foreign address.
- R6: In receiver mode, data bits are sampled on rising SCL, MSB first. With `ack_enable` at 1, the byte is acknowledged, appears on `rx_data`, and `status` becomes 0x80 after an own-address write or 0x90 after a general call.
- R7: With `ack_enable` at 0, a received byte is not acknowledged and `status` becomes 0x88 (0x98 for a general call). The block then leaves the addressed state, so a following STOP raises no flag.
- R8: A STOP, or a repeated START, seen while addressed between bytes (at most one SCL rise into the byte) gives `status` 0xA0 with `irq_flag` set and SCL not held. A repeated START then goes on to receive a new address.
- R9: An own address with a read bit (1) gives `status` 0xA8. On the clearing pulse, `tx_data` is loaded and its MSB is put on SDA. Each following bit is put on SDA after a falling SCL edge.
- R10: After a transmitted byte, a master ACK gives `status` 0xB8 and a master NACK gives 0xC0. After 0xC0 the block is no longer addressed.
- R11: A byte loaded while `ack_enable` is 0 is the last byte. If the master still ACKs it, `status` is 0xC8, SDA is released and the block is no longer addressed, so further clocks read all ones.
- R12: A START or STOP seen while addressed after the second SCL rise of a byte is a bus error. It gives `status` 0x00 with `irq_flag` set, both lines released, and a return to the not-addressed state.
- R13: A high pulse on SCL shorter than `FILT_LEN` clock cycles is not counted as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Level of the SCL bus line |
| sda_i | input | 1 | Level of the SDA bus line |
| scl_drive_low | output | 1 | 1 pulls SCL low (clock stretching) |
| sda_drive_low | output | 1 | 1 pulls SDA low (ACK or a 0 data bit) |
| own_addr | input | 7 | Own slave address |
| gc_enable | input | 1 | Answer the general-call address |
| ack_enable | input | 1 | Acknowledge addresses and bytes; 0 marks the next transmit byte as the last one |
| flag_clear | input | 1 | One-cycle pulse that clears the flag and continues the transfer |
| tx_data | input | 8 | Byte loaded for transmission on the clearing pulse |
| rx_data | output | 8 | Last byte received |
| status | output | 8 | Status code of the last event |
| irq_flag | output | 1 | Event flag |

## Verification
The hardest cases to reach are those that depend on where a bus condition lands inside a byte. A repeated START or STOP one SCL rise into a byte must give 0xA0, while the same condition a few bits later must give the bus-error code. The master model is built from single-bit clock tasks, so the bench can break off a byte after a chosen number of bits and place the condition exactly there. The filter case uses a two-cycle SCL pulse inserted between data bits, and it is judged by whether the received byte still comes out intact.

// File: rtl/i2c_slv_pkg.sv
// Package: shared widths, engine states and status codes of the I2C slave.
// Assumes 7-bit addressing and 8-bit data bytes.
package i2c_slv_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_TX
    } eng_state_t;

    localparam logic [7:0] SC_BUS_ERR  = 8'h00;
    localparam logic [7:0] SC_OWN_W    = 8'h60;
    localparam logic [7:0] SC_GC_W     = 8'h70;
    localparam logic [7:0] SC_RX_ACK   = 8'h80;
    localparam logic [7:0] SC_RX_NACK  = 8'h88;
    localparam logic [7:0] SC_GC_ACK   = 8'h90;
    localparam logic [7:0] SC_GC_NACK  = 8'h98;
    localparam logic [7:0] SC_STOP_RS  = 8'hA0;
    localparam logic [7:0] SC_OWN_R    = 8'hA8;
    localparam logic [7:0] SC_TX_ACK   = 8'hB8;
    localparam logic [7:0] SC_TX_NACK  = 8'hC0;
    localparam logic [7:0] SC_TX_LAST  = 8'hC8;
    localparam logic [7:0] SC_IDLE     = 8'hF8;

endpackage

// File: rtl/i2c_line_filter.sv
// Module: synchroniser plus stability filter for one open-drain bus line.
// The filtered output takes a new level only after the synchronised input
// has shown it for FILT_LEN consecutive cycles. Resets to the idle-high level.
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          stab_cnt;
    logic                   filt_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];
    assign line_o = filt_q;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    // Accept a new level once it has been stable long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q   <= 1'b1;
            stab_cnt <= '0;
        end else if (synced == filt_q) begin
            stab_cnt <= '0;
        end else if (stab_cnt == CW'(FILT_LEN - 1)) begin
            filt_q   <= synced;
            stab_cnt <= '0;
        end else begin
            stab_cnt <= stab_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
// Module: derives SCL edges and START/STOP conditions from the filtered lines.
// Assumes the filtered SCL and SDA never change in the same cycle.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_prev;
    logic sda_prev;

    // Remember the previous filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_f;
            sda_prev <= sda_f;
        end
    end

    // Decode the edges and conditions.
    always_comb begin
        scl_rise  = scl_f & ~scl_prev;
        scl_fall  = ~scl_f & scl_prev;
        start_det = scl_f & scl_prev & sda_prev & ~sda_f;
        stop_det  = scl_f & scl_prev & ~sda_prev & sda_f;
    end
endmodule

// File: rtl/i2c_slave_engine.sv
// Module: protocol engine of the I2C slave. It counts bits, matches the
// address, drives ACK and transmit bits, and reports each event with a
// status code and a flag. Assumes single-cycle event pulses from
// i2c_bus_events. Event updates take priority over a same-cycle clear.
module i2c_slave_engine
    import i2c_slv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_f,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_enable,
    input  logic              ack_enable,
    input  logic              flag_clear,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_data,
    output logic [7:0]        status,
    output logic              irq_flag,
    output logic              scl_low,
    output logic              sda_low
);
    localparam logic [3:0] LAST_BIT = 4'(DATA_W);
    localparam logic [3:0] ACK_BIT  = 4'(DATA_W + 1);

    eng_state_t        state;
    logic [3:0]        bit_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_q;
    logic [7:0]        status_q;
    logic              flag_q;
    logic              hold_q;
    logic              sda_q;
    logic              gc_q;
    logic              rw_q;
    logic              ack_q;
    logic              last_q;
    logic              m_ack_q;
    logic              tx_pend;
    logic              addressed;
    logic [ADDR_W-1:0] addr_field;
    logic              own_hit;
    logic              gc_hit;

    assign rx_data  = rx_q;
    assign status   = status_q;
    assign irq_flag = flag_q;
    assign scl_low  = hold_q;
    assign sda_low  = sda_q;

    // Decode the address byte and the addressed condition.
    always_comb begin
        addressed  = (state == ST_RX) || (state == ST_TX);
        addr_field = rx_sh[DATA_W-1:1];
        own_hit    = (addr_field == own_addr) && (addr_field != '0);
        gc_hit     = (addr_field == '0) && gc_enable && !rx_sh[0];
    end

    // Main sequencer: clear handling, bus conditions, then bit-level work.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rx_q     <= '0;
            status_q <= SC_IDLE;
            flag_q   <= 1'b0;
            hold_q   <= 1'b0;
            sda_q    <= 1'b0;
            gc_q     <= 1'b0;
            rw_q     <= 1'b0;
            ack_q    <= 1'b0;
            last_q   <= 1'b0;
            m_ack_q  <= 1'b0;
            tx_pend  <= 1'b0;
        end else begin
            if (flag_clear) begin
                flag_q   <= 1'b0;
                hold_q   <= 1'b0;
                status_q <= SC_IDLE;
                if (tx_pend) begin
                    tx_sh   <= tx_data;
                    sda_q   <= ~tx_data[DATA_W-1];
                    last_q  <= ~ack_enable;
                    tx_pend <= 1'b0;
                end
            end

            if (start_det || stop_det) begin
                sda_q   <= 1'b0;
                hold_q  <= 1'b0;
                bit_cnt <= '0;
                tx_pend <= 1'b0;
                if (addressed && bit_cnt >= 4'd2) begin
                    status_q <= SC_BUS_ERR;
                    flag_q   <= 1'b1;
                    state    <= ST_IDLE;
                end else begin
                    if (addressed) begin
                        status_q <= SC_STOP_RS;
                        flag_q   <= 1'b1;
                    end
                    state <= start_det ? ST_ADDR : ST_IDLE;
                end
            end else if (scl_rise && state != ST_IDLE) begin
                bit_cnt <= bit_cnt + 4'd1;
                if (bit_cnt < LAST_BIT)
                    rx_sh <= {rx_sh[DATA_W-2:0], sda_f};
                if (state == ST_TX && bit_cnt == LAST_BIT)
                    m_ack_q <= ~sda_f;
            end else if (scl_fall && state != ST_IDLE) begin
                case (state)
                    ST_ADDR: begin
                        if (bit_cnt == LAST_BIT) begin
                            if ((own_hit || gc_hit) && ack_enable) begin
                                sda_q <= 1'b1;
                                gc_q  <= gc_hit;
                                rw_q  <= rx_sh[0];
                                state <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (bit_cnt == ACK_BIT) begin
                            sda_q   <= 1'b0;
                            bit_cnt <= '0;
                            flag_q  <= 1'b1;
                            hold_q  <= 1'b1;
                            if (rw_q) begin
                                status_q <= SC_OWN_R;
                                state    <= ST_TX;
                                tx_pend  <= 1'b1;
                            end else begin
                                status_q <= gc_q ? SC_GC_W : SC_OWN_W;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_RX: begin
                        if (bit_cnt == LAST_BIT) begin
                            sda_q <= ack_enable;
                            ack_q <= ack_enable;
                        end else if (bit_cnt == ACK_BIT) begin
                            sda_q   <= 1'b0;
                            bit_cnt <= '0;
                            flag_q  <= 1'b1;
                            hold_q  <= 1'b1;
                            rx_q    <= rx_sh;
                            if (gc_q) status_q <= ack_q ? SC_GC_ACK : SC_GC_NACK;
                            else      status_q <= ack_q ? SC_RX_ACK : SC_RX_NACK;
                            if (!ack_q) state <= ST_IDLE;
                        end
                    end
                    ST_TX: begin
                        if (bit_cnt >= 4'd1 && bit_cnt < LAST_BIT) begin
                            sda_q <= ~tx_sh[DATA_W-2];
                            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                        end else if (bit_cnt == LAST_BIT) begin
                            sda_q <= 1'b0;
                        end else if (bit_cnt == ACK_BIT) begin
                            bit_cnt <= '0;
                            flag_q  <= 1'b1;
                            hold_q  <= 1'b1;
                            if (!m_ack_q) begin
                                status_q <= SC_TX_NACK;
                                state    <= ST_IDLE;
                            end else if (last_q) begin
                                status_q <= SC_TX_LAST;
                                state    <= ST_IDLE;
                            end else begin
                                status_q <= SC_TX_ACK;
                                tx_pend  <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_status_slave.sv
// Module: top of the I2C slave with status-code reporting.
// Filters both bus lines, decodes bus events, and runs the protocol engine.
// Assumes that external pull-ups and the pad logic turn *_drive_low into
// open-drain pulls.
module i2c_status_slave
    import i2c_slv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_enable,
    input  logic              ack_enable,
    input  logic              flag_clear,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_data,
    output logic [7:0]        status,
    output logic              irq_flag
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_lines = {sda_i, scl_i};

    // One filter per bus line: index 0 is SCL, index 1 is SDA.
    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        i2c_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    i2c_bus_events ev_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (filt_lines[0]),
        .sda_f     (filt_lines[1]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_slave_engine eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .sda_f      (filt_lines[1]),
        .own_addr   (own_addr),
        .gc_enable  (gc_enable),
        .ack_enable (ack_enable),
        .flag_clear (flag_clear),
        .tx_data    (tx_data),
        .rx_data    (rx_data),
        .status     (status),
        .irq_flag   (irq_flag),
        .scl_low    (scl_drive_low),
        .sda_low    (sda_drive_low)
    );
endmodule

// File: rtl/i2c_status_slave_chk.sv
// Checker: temporal properties of the I2C slave, bound to the top module.
module i2c_status_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_drive_low,
    input logic       sda_drive_low,
    input logic [7:0] status,
    input logic       irq_flag,
    input logic       flag_clear,
    input logic       start_det,
    input logic       stop_det
);
    // R1: the flag is set exactly when a non-idle code is shown
    p_flag_status_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag == (status != 8'hF8));

    // R3: SCL is only stretched while an event is pending
    p_hold_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_low |-> irq_flag);

    // R3: the stretch persists until software clears it
    p_hold_until_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && !flag_clear) |=> scl_drive_low);

    // R8: a bus condition releases both lines
    p_cond_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> (!scl_drive_low && !sda_drive_low));

    // R12: only defined codes are ever reported
    p_status_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        status inside {8'h00, 8'h60, 8'h70, 8'h80, 8'h88, 8'h90, 8'h98,
                       8'hA0, 8'hA8, 8'hB8, 8'hC0, 8'hC8, 8'hF8});
endmodule

bind i2c_status_slave i2c_status_slave_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .status        (status),
    .irq_flag      (irq_flag),
    .flag_clear    (flag_clear),
    .start_det     (start_det),
    .stop_det      (stop_det)
);

// File: tb/i2c_status_slave_tb_top.sv
// Bench: directed tests with a bit-level I2C master model on open-drain lines.
module i2c_status_slave_tb_top;
    localparam int HALF = 20;
    localparam logic [6:0] MY_ADDR = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       scl_drive_low, sda_drive_low;
    logic [6:0] own_addr = MY_ADDR;
    logic       gc_enable = 1'b0;
    logic       ack_enable = 1'b1;
    logic       flag_clear = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data, status;
    logic       irq_flag;
    logic       scl_line, sda_line;

    int tests = 0;
    int fails = 0;

    assign scl_line = scl_m & ~scl_drive_low;
    assign sda_line = sda_m & ~sda_drive_low;

    always #5 clk = ~clk;

    i2c_status_slave dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_line),
        .sda_i         (sda_line),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .own_addr      (own_addr),
        .gc_enable     (gc_enable),
        .ack_enable    (ack_enable),
        .flag_clear    (flag_clear),
        .tx_data       (tx_data),
        .rx_data       (rx_data),
        .status        (status),
        .irq_flag      (irq_flag)
    );

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clock_bit(input logic b, output logic s);
        sda_m = b;
        wcyc(HALF);
        scl_m = 1'b1;
        wait (scl_line == 1'b1);
        wcyc(HALF / 2);
        s = sda_line;
        wcyc(HALF / 2);
        scl_m = 1'b0;
        wcyc(HALF);
    endtask

    task automatic m_start();
        sda_m = 1'b1;
        wcyc(HALF);
        scl_m = 1'b1;
        wait (scl_line == 1'b1);
        wcyc(HALF);
        sda_m = 1'b0;
        wcyc(HALF);
        scl_m = 1'b0;
        wcyc(HALF);
    endtask

    task automatic m_stop();
        sda_m = 1'b0;
        wcyc(HALF);
        scl_m = 1'b1;
        wait (scl_line == 1'b1);
        wcyc(HALF);
        sda_m = 1'b1;
        wcyc(HALF);
    endtask

    task automatic m_write(input logic [7:0] b, input int glitch_after, output logic nack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(b[i], s);
            if (i == glitch_after) begin
                scl_m = 1'b1;
                wcyc(2);
                scl_m = 1'b0;
                wcyc(6);
            end
        end
        clock_bit(1'b1, nack);
    endtask

    task automatic m_read(input logic ack_bit, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            d[i] = s;
        end
        clock_bit(ack_bit, s);
    endtask

    task automatic sw_clear();
        flag_clear = 1'b1;
        wcyc(1);
        flag_clear = 1'b0;
        wcyc(2);
    endtask

    task automatic t_reset();
        chk("R1", "status", status, 8'hF8);
        chk("R1", "flag", irq_flag, 0);
        chk("R1", "scl drive", scl_drive_low, 0);
        chk("R1", "sda drive", sda_drive_low, 0);
    endtask

    task automatic t_own_write();
        logic n;
        m_start();
        m_write({MY_ADDR, 1'b0}, -1, n);
        chk("R2", "addr ack", n, 0);
        chk("R2", "status", status, 8'h60);
        chk("R2", "flag", irq_flag, 1);
        chk("R2", "scl held", scl_drive_low, 1);
        wcyc(60);
        chk("R3", "still held", scl_drive_low, 1);
        sw_clear();
        chk("R3", "flag cleared", irq_flag, 0);
        chk("R3", "status idle", status, 8'hF8);
        chk("R3", "scl released", scl_drive_low, 0);
        m_write(8'hC3, -1, n);
        chk("R6", "data ack", n, 0);
        chk("R6", "status", status, 8'h80);
        chk("R6", "rx byte", rx_data, 8'hC3);
        sw_clear();
        m_write(8'h3C, -1, n);
        chk("R6", "rx byte 2", rx_data, 8'h3C);
        sw_clear();
        m_stop();
        chk("R8", "stop status", status, 8'hA0);
        chk("R8", "stop flag", irq_flag, 1);
        chk("R8", "stop no hold", scl_drive_low, 0);
        sw_clear();
    endtask

    task automatic t_reject();
        logic n;
        m_start();
        m_write({7'h33, 1'b0}, -1, n);
        chk("R4", "foreign nack", n, 1);
        chk("R4", "foreign flag", irq_flag, 0);
        m_stop();
        ack_enable = 1'b0;
        m_start();
        m_write({MY_ADDR, 1'b0}, -1, n);
        chk("R4", "disabled nack", n, 1);
        chk("R4", "disabled flag", irq_flag, 0);
        m_stop();
        ack_enable = 1'b1;
        chk("R4", "after stop flag", irq_flag, 0);
    endtask

    task automatic t_gencall();
        logic n;
        gc_enable = 1'b1;
        m_start();
        m_write(8'h00, -1, n);
        chk("R5", "gc ack", n, 0);
        chk("R5", "gc status", status, 8'h70);
        sw_clear();
        m_write(8'h5E, -1, n);
        chk("R6", "gc data status", status, 8'h90);
        chk("R6", "gc rx byte", rx_data, 8'h5E);
        ack_enable = 1'b0;
        sw_clear();
        m_write(8'h11, -1, n);
        chk("R7", "gc nack", n, 1);
        chk("R7", "gc nack status", status, 8'h98);
        ack_enable = 1'b1;
        sw_clear();
        m_stop();
        chk("R7", "gc stop no flag", irq_flag, 0);
        gc_enable = 1'b0;
        m_start();
        m_write(8'h00, -1, n);
        chk("R5", "gc disabled nack", n, 1);
        chk("R5", "gc disabled flag", irq_flag, 0);
        m_stop();
    endtask

    task automatic t_rx_nack();
        logic n;
        m_start();
        m_write({MY_ADDR, 1'b0}, -1, n);
        ack_enable = 1'b0;
        sw_clear();
        m_write(8'hA5, -1, n);
        chk("R7", "nack bit", n, 1);
        chk("R7", "status", status, 8'h88);
        chk("R7", "rx byte", rx_data, 8'hA5);
        ack_enable = 1'b1;
        sw_clear();
        m_stop();
        chk("R7", "stop ignored flag", irq_flag, 0);
        chk("R7", "stop ignored status", status, 8'hF8);
    endtask

    task automatic t_restart_read();
        logic n;
        logic [7:0] d;
        m_start();
        m_write({MY_ADDR, 1'b0}, -1, n);
        sw_clear();
        m_write(8'h01, -1, n);
        sw_clear();
        m_start();
        chk("R8", "restart status", status, 8'hA0);
        chk("R8", "restart flag", irq_flag, 1);
        sw_clear();
        m_write({MY_ADDR, 1'b1}, -1, n);
        chk("R9", "read addr ack", n, 0);
        chk("R9", "read status", status, 8'hA8);
        tx_data = 8'h96;
        sw_clear();
        m_read(1'b0, d);
        chk("R9", "tx byte", d, 8'h96);
        chk("R10", "master ack status", status, 8'hB8);
        tx_data = 8'h4B;
        sw_clear();
        m_read(1'b1, d);
        chk("R9", "tx byte 2", d, 8'h4B);
        chk("R10", "master nack status", status, 8'hC0);
        sw_clear();
        m_stop();
        chk("R10", "not addressed after nack", irq_flag, 0);
    endtask

    task automatic t_last_byte();
        logic n;
        logic [7:0] d;
        m_start();
        m_write({MY_ADDR, 1'b1}, -1, n);
        tx_data = 8'hE1;
        ack_enable = 1'b0;
        sw_clear();
        ack_enable = 1'b1;
        m_read(1'b0, d);
        chk("R11", "last byte", d, 8'hE1);
        chk("R11", "status", status, 8'hC8);
        chk("R11", "sda released", sda_drive_low, 0);
        sw_clear();
        m_read(1'b1, d);
        chk("R11", "after last reads ones", d, 8'hFF);
        chk("R11", "no further flag", irq_flag, 0);
        m_stop();
    endtask

    task automatic t_bus_error();
        logic n, s;
        m_start();
        m_write({MY_ADDR, 1'b0}, -1, n);
        sw_clear();
        clock_bit(1'b1, s);
        clock_bit(1'b0, s);
        clock_bit(1'b1, s);
        m_stop();
        chk("R12", "status", status, 8'h00);
        chk("R12", "flag", irq_flag, 1);
        chk("R12", "scl free", scl_drive_low, 0);
        chk("R12", "sda free", sda_drive_low, 0);
        sw_clear();
    endtask

    task automatic t_glitch();
        logic n;
        m_start();
        m_write({MY_ADDR, 1'b0}, -1, n);
        sw_clear();
        m_write(8'hB2, 4, n);
        chk("R13", "status", status, 8'h80);
        chk("R13", "rx byte intact", rx_data, 8'hB2);
        sw_clear();
        m_stop();
        sw_clear();
    endtask

    initial begin
        wcyc(5);
        rst_n = 1'b1;
        wcyc(10);
        t_reset();
        t_own_write();
        t_reject();
        t_gencall();
        t_rx_nack();
        t_restart_read();
        t_last_byte();
        t_bus_error();
        t_glitch();
        wcyc(20);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule